// File: doc/BRIEF.md
# Shared-Pin Ethernet Status Indicator and GPIO Multiplexer

This block owns a small group of shared pads. Each pad can serve as a general-purpose pin or as an active-low Ethernet status lamp. In GPIO mode, a two-bit mode field per pin chooses one of three behaviours. The pin can be an input, a push-pull output that drives the requested level, or an open-drain output that pulls low for a 0 and floats for a 1. Pad levels pass through a two-stage synchronizer before they reach the read-back bus.

When LED mode is selected, the three lowest pins become status lamps and only ever sink current. Pin 0 shows speed. It stays lit unless the link is confirmed up at 10 Mb/s. Pin 1 shows link and activity. It stays lit while the link is up and blinks off for a fixed number of ticks when traffic occurs. After each blink it must stay lit for the same number of ticks before it may blink again. Activity seen during that time is remembered and causes one more blink. Pin 2 lights for a full-duplex link. The blink timing is counted in ticks of an external 1 ms strobe. The tick count per interval is a parameter.

Top module: `eth_ind_gpio`

## Requirements
- R1: In GPIO mode, a pin whose mode field (bits 2i+1:2i of `cfg_mode`) is 2'b01 is push-pull. It has `pad_oe` high and `pad_do` equal to its `gpio_out` bit.
- R2: In GPIO mode, a pin with mode 2'b10 is open-drain. When its `gpio_out` bit is 0, it has `pad_oe` high and `pad_do` low. When the bit is 1, `pad_oe` is low.
- R3: In GPIO mode, a pin with mode 2'b00 or 2'b11 is an input, with `pad_oe` low. Whenever `pad_oe` is low, `pad_do` is 0.
- R4: With `led_en` high, pins 0..2 ignore `cfg_mode` and `gpio_out`. `pad_do` is then always 0 on those pins, and a lit lamp is shown as `pad_oe` high.
- R5: The speed lamp on pin 0 is lit unless `link_up`, `cable_in` and neither `speed_100` nor `aneg_busy` are all true (confirmed 10 Mb/s).
- R6: The link lamp on pin 1 is lit whenever the link is up and no blink is in progress. It is dark while the link is down.
- R7: A `tx_act` or `rx_act` pulse seen with the link up and the lamp in steady-on turns the lamp off from the next cycle. It stays off until the PULSE_TICKS-th `tick_1ms` pulse.
- R8: After an off interval, the lamp stays lit for PULSE_TICKS ticks. It then blinks again only if activity arrived during the off or hold interval, and otherwise returns to steady-on.
- R9: If the link drops, the link lamp goes dark on the next cycle and any remembered activity is discarded.
- R10: The duplex lamp on pin 2 is lit exactly when `link_up` and `full_dup` are both high.
- R11: `gpio_rd` shows the pad levels after two clock edges of synchronization, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| led_en | input | 1 | Selects LED mode for pins 0..2 |
| cfg_mode | input | 2*NUM_PINS | Per-pin mode field: 00/11 input, 01 push-pull, 10 open-drain |
| gpio_out | input | NUM_PINS | Requested output levels |
| pad_in | input | NUM_PINS | Levels seen at the pads |
| gpio_rd | output | NUM_PINS | Synchronized pad levels |
| pad_oe | output | NUM_PINS | Output driver enable per pad |
| pad_do | output | NUM_PINS | Output level per pad |
| link_up | input | 1 | Valid link present |
| speed_100 | input | 1 | Link speed is 100 Mb/s |
| aneg_busy | input | 1 | Autonegotiation in progress |
| cable_in | input | 1 | Cable detected |
| full_dup | input | 1 | Link is full duplex |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| tick_1ms | input | 1 | Single-cycle timing strobe |

## Verification
The hardest case to reach is the re-blink decision at the end of a hold interval. Activity has to arrive while the lamp is already dark or in its minimum-on time, and it must still produce exactly one more blink. A variant is a link drop while activity is pending, after which no blink may follow. The bench drives the timing strobe itself, one pulse at a time, with a shortened interval. This lets it place an activity pulse inside a chosen interval and drop the link at a known point, then step through the following ticks to confirm the lamp stays steady.

// File: rtl/eth_ind_pkg.sv
package eth_ind_pkg;

  typedef enum logic [1:0] {
    PM_IN   = 2'b00,
    PM_PP   = 2'b01,
    PM_OD   = 2'b10,
    PM_IN_B = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    LA_IDLE = 2'b00,
    LA_ON   = 2'b01,
    LA_OFF  = 2'b10,
    LA_HOLD = 2'b11
  } la_state_e;

  // Returns {oe, do} for a pin in GPIO mode.
  function automatic logic [1:0] gpio_drive(input logic [1:0] mode, input logic val);
    logic [1:0] r;
    case (pin_mode_e'(mode))
      PM_PP:   r = {1'b1, val};
      PM_OD:   r = {~val, 1'b0};
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  // Speed lamp dark only for a confirmed 10 Mb/s link.
  function automatic logic speed_lamp(input logic link, input logic spd,
                                      input logic aneg, input logic cable);
    return !(link && cable && !spd && !aneg);
  endfunction

  function automatic logic duplex_lamp(input logic link, input logic fd);
    return link && fd;
  endfunction

endpackage

// File: rtl/eth_ind_sync.sv
module eth_ind_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eth_ind_linkact.sv
module eth_ind_linkact
  import eth_ind_pkg::*;
#(
  parameter int PULSE_TICKS = 80,
  parameter int CNT_W       = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic act_in,
  input  logic tick,
  output logic lit,
  output logic off,
  output logic pend
);
  la_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             cnt_done;
  logic             timing;

  assign timing   = (state_q == LA_OFF) || (state_q == LA_HOLD);
  assign cnt_done = tick && (cnt_q == CNT_W'(PULSE_TICKS - 1));

  always_comb begin
    state_n = state_q;
    if (!link_up) begin
      state_n = LA_IDLE;
    end else begin
      case (state_q)
        LA_IDLE: state_n = LA_ON;
        LA_ON:   if (act_in) state_n = LA_OFF;
        LA_OFF:  if (cnt_done) state_n = LA_HOLD;
        LA_HOLD: if (cnt_done) state_n = (pend_q || act_in) ? LA_OFF : LA_ON;
        default: state_n = LA_IDLE;
      endcase
    end
  end

  always_comb begin
    pend_n = pend_q;
    if (!link_up)                              pend_n = 1'b0;
    else if ((state_q == LA_HOLD) && cnt_done) pend_n = 1'b0;
    else if (timing && act_in)                 pend_n = 1'b1;
  end

  always_comb begin
    cnt_n = cnt_q;
    if (state_n != state_q)  cnt_n = '0;
    else if (timing && tick) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LA_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      pend_q  <= pend_n;
    end
  end

  assign lit  = (state_q == LA_ON) || (state_q == LA_HOLD);
  assign off  = (state_q == LA_OFF);
  assign pend = pend_q;
endmodule

// File: rtl/eth_ind_pad.sv
module eth_ind_pad
  import eth_ind_pkg::*;
#(
  parameter bit LED_CAPABLE = 1'b1
) (
  input  logic       led_en,
  input  logic       led_lit,
  input  logic [1:0] mode,
  input  logic       gout,
  output logic       oe,
  output logic       dout
);
  logic [1:0] gp;
  assign gp = gpio_drive(mode, gout);

  if (LED_CAPABLE) begin : g_led
    always_comb begin
      if (led_en) begin
        oe   = led_lit;
        dout = 1'b0;
      end else begin
        oe   = gp[1];
        dout = gp[0];
      end
    end
  end else begin : g_plain
    assign oe   = gp[1];
    assign dout = gp[0];
  end
endmodule

// File: rtl/eth_ind_gpio.sv
module eth_ind_gpio
  import eth_ind_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int PULSE_TICKS = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  led_en,
  input  logic [2*NUM_PINS-1:0] cfg_mode,
  input  logic [NUM_PINS-1:0]   gpio_out,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   gpio_rd,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_do,
  input  logic                  link_up,
  input  logic                  speed_100,
  input  logic                  aneg_busy,
  input  logic                  cable_in,
  input  logic                  full_dup,
  input  logic                  tx_act,
  input  logic                  rx_act,
  input  logic                  tick_1ms
);
  localparam int LED_PINS = 3;
  localparam int CNT_W    = $clog2(PULSE_TICKS + 1);

  logic          la_lit, la_off, la_pend;
  logic          act_any;
  logic [LED_PINS-1:0] lamp;

  assign act_any = tx_act | rx_act;

  eth_ind_linkact #(
    .PULSE_TICKS(PULSE_TICKS),
    .CNT_W      (CNT_W)
  ) u_linkact (
    .clk    (clk),
    .rst_n  (rst_n),
    .link_up(link_up),
    .act_in (act_any),
    .tick   (tick_1ms),
    .lit    (la_lit),
    .off    (la_off),
    .pend   (la_pend)
  );

  assign lamp[0] = speed_lamp(link_up, speed_100, aneg_busy, cable_in);
  assign lamp[1] = la_lit;
  assign lamp[2] = duplex_lamp(link_up, full_dup);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < LED_PINS) begin : g_ledpin
      eth_ind_pad #(.LED_CAPABLE(1'b1)) u_pad (
        .led_en (led_en),
        .led_lit(lamp[i]),
        .mode   (cfg_mode[2*i+1:2*i]),
        .gout   (gpio_out[i]),
        .oe     (pad_oe[i]),
        .dout   (pad_do[i])
      );
    end else begin : g_gppin
      eth_ind_pad #(.LED_CAPABLE(1'b0)) u_pad (
        .led_en (1'b0),
        .led_lit(1'b0),
        .mode   (cfg_mode[2*i+1:2*i]),
        .gout   (gpio_out[i]),
        .oe     (pad_oe[i]),
        .dout   (pad_do[i])
      );
    end
  end

  eth_ind_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (gpio_rd)
  );
endmodule

// File: rtl/eth_ind_gpio_chk.sv
module eth_ind_gpio_chk #(
  parameter int NUM_PINS    = 3,
  parameter int PULSE_TICKS = 80
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  led_en,
  input logic [2*NUM_PINS-1:0] cfg_mode,
  input logic                  link_up,
  input logic                  full_dup,
  input logic                  tick_1ms,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_do,
  input logic                  la_lit,
  input logic                  la_off,
  input logic                  la_pend
);
  logic [7:0] hold_cnt;

  // Ticks spent lit since the last off interval; saturates at PULSE_TICKS.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                hold_cnt <= 8'(PULSE_TICKS);
    else if (!la_lit && !la_off)               hold_cnt <= 8'(PULSE_TICKS);
    else if (la_off)                           hold_cnt <= '0;
    else if (tick_1ms && (int'(hold_cnt) < PULSE_TICKS)) hold_cnt <= hold_cnt + 8'd1;
  end

  AST_LED_SINK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    led_en |-> (pad_do[2:0] == 3'b000)); // R4

  AST_NO_DRIVE_UNLESS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_do & ~pad_oe) == '0)); // R3

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_in
    AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(led_en && i < 3) && (cfg_mode[2*i+1:2*i] == 2'b00 || cfg_mode[2*i+1:2*i] == 2'b11))
      |-> !pad_oe[i]); // R3
  end

  AST_LINK_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (!la_lit && !la_off && !la_pend)); // R9

  AST_BLINK_FROM_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(la_off) |-> ($past(la_lit) && $past(link_up))); // R7

  AST_MIN_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(la_off) |-> (int'(hold_cnt) >= PULSE_TICKS)); // R8

  AST_DUPLEX_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (led_en && !full_dup) |-> !pad_oe[2]); // R10
endmodule

bind eth_ind_gpio eth_ind_gpio_chk #(
  .NUM_PINS   (NUM_PINS),
  .PULSE_TICKS(PULSE_TICKS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .led_en  (led_en),
  .cfg_mode(cfg_mode),
  .link_up (link_up),
  .full_dup(full_dup),
  .tick_1ms(tick_1ms),
  .pad_oe  (pad_oe),
  .pad_do  (pad_do),
  .la_lit  (la_lit),
  .la_off  (la_off),
  .la_pend (la_pend)
);

// File: tb/eth_ind_gpio_tb.sv
module eth_ind_gpio_tb;
  localparam int NP = 3;
  localparam int PT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic led_en = 1'b0;
  logic [2*NP-1:0] cfg_mode = '0;
  logic [NP-1:0] gpio_out = '0, pad_in = '0;
  logic [NP-1:0] gpio_rd, pad_oe, pad_do;
  logic link_up = 0, speed_100 = 0, aneg_busy = 0, cable_in = 0, full_dup = 0;
  logic tx_act = 0, rx_act = 0, tick_1ms = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  eth_ind_gpio #(.NUM_PINS(NP), .PULSE_TICKS(PT), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .led_en(led_en), .cfg_mode(cfg_mode),
    .gpio_out(gpio_out), .pad_in(pad_in), .gpio_rd(gpio_rd),
    .pad_oe(pad_oe), .pad_do(pad_do), .link_up(link_up),
    .speed_100(speed_100), .aneg_busy(aneg_busy), .cable_in(cable_in),
    .full_dup(full_dup), .tx_act(tx_act), .rx_act(rx_act), .tick_1ms(tick_1ms)
  );

  // {led, mode[5:0], gout[2:0], link,spd,aneg,cable,fd, 3'b0, exp_oe[2:0], exp_do[2:0]}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 6'b000000, 3'b111, 5'b00000, 3'b000, 3'b000, 3'b000}, // R3 all inputs
    {1'b0, 6'b010101, 3'b101, 5'b00000, 3'b000, 3'b111, 3'b101}, // R1 push-pull
    {1'b0, 6'b101010, 3'b101, 5'b00000, 3'b000, 3'b010, 3'b000}, // R2 open-drain
    {1'b0, 6'b100001, 3'b011, 5'b00000, 3'b000, 3'b101, 3'b001}, // R1 R2 R3 mixed
    {1'b0, 6'b111111, 3'b111, 5'b00000, 3'b000, 3'b000, 3'b000}, // R3 mode 11
    {1'b1, 6'b010101, 3'b111, 5'b11011, 3'b000, 3'b111, 3'b000}, // R4 R5 R6 R10 100M FD
    {1'b1, 6'b010101, 3'b111, 5'b10010, 3'b000, 3'b010, 3'b000}, // R5 10M half
    {1'b1, 6'b010101, 3'b111, 5'b10111, 3'b000, 3'b111, 3'b000}, // R5 aneg
    {1'b1, 6'b010101, 3'b111, 5'b00000, 3'b000, 3'b001, 3'b000}, // R5 R6 no cable
    {1'b1, 6'b010101, 3'b111, 5'b00010, 3'b000, 3'b001, 3'b000}, // R5 cable no link
    {1'b1, 6'b010101, 3'b111, 5'b11010, 3'b000, 3'b011, 3'b000}  // R10 half duplex
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic pulse_tx;
    @(negedge clk) tx_act = 1'b1;
    @(negedge clk) tx_act = 1'b0;
  endtask

  task automatic pulse_rx;
    @(negedge clk) rx_act = 1'b1;
    @(negedge clk) rx_act = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    pad_in = 3'b110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R3 reset state
    check("R3 reset oe", 32'(pad_oe), 32'h0);
    check("R3 reset do", 32'(pad_do), 32'h0);
    check("R11 reset rd", 32'(gpio_rd), 32'h0);
    pad_in = 3'b000;
    repeat (3) @(negedge clk);

    // R11 synchronizer latency
    pad_in = 3'b101;
    @(negedge clk);
    check("R11 one edge", 32'(gpio_rd), 32'h0);
    @(negedge clk);
    check("R11 two edges", 32'(gpio_rd), 32'h5);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      led_en    = VEC[v][23];
      cfg_mode  = VEC[v][22:17];
      gpio_out  = VEC[v][16:14];
      link_up   = VEC[v][13];
      speed_100 = VEC[v][12];
      aneg_busy = VEC[v][11];
      cable_in  = VEC[v][10];
      full_dup  = VEC[v][9];
      repeat (3) @(negedge clk);
      check($sformatf("R1-table oe v%0d", v), 32'(pad_oe), 32'(VEC[v][5:3]));
      check($sformatf("R4-table do v%0d", v), 32'(pad_do), 32'(VEC[v][2:0]));
    end

    // Link/activity blinking
    led_en = 1'b1; link_up = 1'b1; cable_in = 1'b1; speed_100 = 1'b1; full_dup = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 steady on", 32'(pad_oe[1]), 32'h1);
    pulse_tx;
    check("R7 off after tx", 32'(pad_oe[1]), 32'h0);
    tick_n(PT - 1);
    check("R7 still off", 32'(pad_oe[1]), 32'h0);
    pulse_rx;                       // pending during off
    tick_n(1);
    check("R7 off ends at last tick", 32'(pad_oe[1]), 32'h1);
    tick_n(PT - 1);
    check("R8 hold lit", 32'(pad_oe[1]), 32'h1);
    tick_n(1);
    check("R8 pending reblink", 32'(pad_oe[1]), 32'h0);
    tick_n(PT);
    check("R8 hold after reblink", 32'(pad_oe[1]), 32'h1);
    tick_n(PT);
    check("R8 back to on", 32'(pad_oe[1]), 32'h1);
    tick_n(2 * PT);
    check("R8 no extra blink", 32'(pad_oe[1]), 32'h1);

    // R9: link drop with pending
    pulse_tx;
    tick_n(PT);
    check("R8 hold entered", 32'(pad_oe[1]), 32'h1);
    pulse_rx;                       // pending during hold
    @(negedge clk) link_up = 1'b0;
    @(negedge clk);
    check("R9 dark on drop", 32'(pad_oe[1]), 32'h0);
    link_up = 1'b1;
    @(negedge clk);
    check("R9 relit", 32'(pad_oe[1]), 32'h1);
    tick_n(3 * PT);
    check("R9 pending discarded", 32'(pad_oe[1]), 32'h1);

    // R9: activity while link down does not blink later
    @(negedge clk) link_up = 1'b0;
    pulse_tx;
    check("R6 dark link down", 32'(pad_oe[1]), 32'h0);
    @(negedge clk) link_up = 1'b1;
    @(negedge clk);
    tick_n(2 * PT);
    check("R9 no blink from down act", 32'(pad_oe[1]), 32'h1);
    check("R4 led do zero", 32'(pad_do), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule